// File: doc/BRIEF.md
# Load-Following Switching Clock Generator

This block produces the switching clock of a switched-capacitor power stage by pulse-frequency regulation. A fast system clock runs the logic. A strobe marks each rising edge of the converter oscillator, and a comparator decision arrives with it. On a strobe, a decision of 1 means that the output voltage has sagged below its reference, and the block then toggles a flip-flop. The flip-flop output is the switching clock, with a 50% duty cycle. Its frequency therefore follows the load, up to half the oscillator rate.

A non-overlap stage turns the switching clock into two phases for the power switches. Between the two phases it inserts a programmable gap, counted in fast-clock cycles. A bypass input makes every oscillator strobe toggle the clock whatever the comparator says, which runs the stage at full rate while a conversion ratio is being searched. The bypass request passes through a flip-flop synchronizer before it changes the toggle gating. A wrapping toggle counter comes out on the ports so that the switching activity can be measured in test.

Top module: `pfm_clkgen`

## Requirements
- R1: While rst_ni is low, sw_clk_o, phi_a_o, phi_b_o and toggle_cnt_o are all 0.
- R2: Take a rising clock edge at which osc_tick_i is 1, cmp_i is 1 and the synchronized mode is regulate. After that edge sw_clk_o is inverted and toggle_cnt_o has increased by one.
- R3: At an edge where osc_tick_i is 1, cmp_i is 0 and the synchronized mode is regulate, sw_clk_o and toggle_cnt_o stay unchanged.
- R4: At an edge where osc_tick_i is 0, sw_clk_o and toggle_cnt_o stay unchanged, whatever the values of cmp_i and bypass_i.
- R5: At every edge with osc_tick_i high, the synchronized mode 1 (bypass) makes sw_clk_o toggle and toggle_cnt_o increment, whatever cmp_i is. The mode used at an edge is bypass_i as sampled SYNC_STAGES edges earlier (2 by default).
- R6: phi_a_o rises only when sw_clk_o was 1 at that edge, and phi_b_o rises only when sw_clk_o was 0 at that edge.
- R7: phi_a_o and phi_b_o are never 1 in the same cycle.
- R8: After a phase falls, both phases stay low for exactly D cycles before the next phase rises. D is the value of dead_i, and a dead_i of 0 counts as 1. Out of reset, phi_b_o rises after D cycles.
- R9: When sw_clk_o no longer matches the active phase (1 for phi_a_o, 0 for phi_b_o), that phase falls at the next edge.
- R10: toggle_cnt_o wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator edge |
| cmp_i | input | 1 | Comparator decision, 1 = output below reference |
| bypass_i | input | 1 | 1 = toggle on every strobe (full-rate search mode) |
| dead_i | input | DEAD_W | Gap between phases in clk_i cycles (0 treated as 1) |
| sw_clk_o | output | 1 | 50% duty-cycle switching clock |
| phi_a_o | output | 1 | Phase driven while the switching clock is high |
| phi_b_o | output | 1 | Phase driven while the switching clock is low |
| toggle_cnt_o | output | CNT_W | Wrapping count of switching-clock toggles |

## Verification
The bench drives strobes every cycle. At that rate the switching clock flips faster than the gap. A design that raised a phase from a stale clock value, or that failed to drop the active phase at once, would then put both phases high together or show the wrong phase. Bypass is switched in the middle of a run while the comparator is held at 0. A design without the synchronizer, or with the wrong number of stages, would show its first full-rate toggle one cycle early or late. The gap is run with settings 0, 1, 2 and 3, so a gap that is one cycle off or a 0 that is not clamped shows up as a phase edge at the wrong cycle. The counter is run through its wrap point, where a saturating counter or a counter of the wrong width would miscompare.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    PH_GAP = 2'd0,
    PH_A   = 2'd1,
    PH_B   = 2'd2
  } phase_e;
endpackage

// File: rtl/pfm_mode_sync.sv
module pfm_mode_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pfm_toggle.sv
module pfm_toggle #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmp_i,
  input  logic             bypass_s_i,
  output logic             sw_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             fire;
  logic             sw_q;
  logic [CNT_W-1:0] cnt_q;

  // oscillator edge gated by droop decision unless bypassed
  assign fire = tick_i & (bypass_s_i | cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      cnt_q <= '0;
    end else if (fire) begin
      sw_q  <= ~sw_q;
      cnt_q <= cnt_q + 1'b1;
    end

  assign sw_o  = sw_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pfm_nonoverlap.sv
module pfm_nonoverlap
  import pfm_pkg::*;
#(
  parameter int unsigned DEAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              phi_a_o,
  output logic              phi_b_o
);
  localparam logic [DEAD_W-1:0] ONE = DEAD_W'(1);

  phase_e            st_q;
  logic [DEAD_W-1:0] gap_q;
  logic [DEAD_W-1:0] dead_eff;
  logic [DEAD_W-1:0] last;

  assign dead_eff = (dead_i == '0) ? ONE : dead_i;
  assign last     = dead_eff - ONE;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= PH_GAP;
      gap_q <= '0;
    end else begin
      unique case (st_q)
        PH_A: if (!sw_i) begin
          st_q  <= PH_GAP;
          gap_q <= '0;
        end
        PH_B: if (sw_i) begin
          st_q  <= PH_GAP;
          gap_q <= '0;
        end
        default: if (gap_q >= last) begin
          st_q  <= sw_i ? PH_A : PH_B;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + ONE;
        end
      endcase
    end

  assign phi_a_o = (st_q == PH_A);
  assign phi_b_o = (st_q == PH_B);
endmodule

// File: rtl/pfm_clkgen.sv
module pfm_clkgen #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DEAD_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              cmp_i,
  input  logic              bypass_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              sw_clk_o,
  output logic              phi_a_o,
  output logic              phi_b_o,
  output logic [CNT_W-1:0]  toggle_cnt_o
);
  logic mode_s;
  logic sw;

  pfm_mode_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bypass_i),
    .q_o   (mode_s)
  );

  pfm_toggle #(.CNT_W(CNT_W)) i_tog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (osc_tick_i),
    .cmp_i     (cmp_i),
    .bypass_s_i(mode_s),
    .sw_o      (sw),
    .cnt_o     (toggle_cnt_o)
  );

  pfm_nonoverlap #(.DEAD_W(DEAD_W)) i_nov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sw_i   (sw),
    .dead_i (dead_i),
    .phi_a_o(phi_a_o),
    .phi_b_o(phi_b_o)
  );

  assign sw_clk_o = sw;
endmodule

// File: rtl/pfm_clkgen_chk.sv
module pfm_clkgen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cmp_i,
  input logic             mode_s_i,
  input logic             sw_i,
  input logic             phi_a_i,
  input logic             phi_b_i,
  input logic [CNT_W-1:0] cnt_i
);
  AST_REG_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cmp_i && !mode_s_i) |=> (sw_i != $past(sw_i)) && (cnt_i == $past(cnt_i) + 1'b1)); // R2
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cmp_i && !mode_s_i) |=> $stable(sw_i) && $stable(cnt_i)); // R3
  AST_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sw_i) && $stable(cnt_i)); // R4
  AST_BYPASS_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_s_i) |=> sw_i != $past(sw_i)); // R5
  AST_PHASE_A_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi_a_i) |-> $past(sw_i)); // R6
  AST_PHASE_B_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi_b_i) |-> !$past(sw_i)); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi_a_i && phi_b_i)); // R7
  AST_GAP_BEFORE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(phi_a_i) || $rose(phi_b_i)) |-> $past(!phi_a_i && !phi_b_i)); // R8
  AST_A_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi_a_i && !sw_i) |=> !phi_a_i); // R9
  AST_B_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi_b_i && sw_i) |=> !phi_b_i); // R9
endmodule

bind pfm_clkgen pfm_clkgen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (osc_tick_i),
  .cmp_i   (cmp_i),
  .mode_s_i(mode_s),
  .sw_i    (sw_clk_o),
  .phi_a_i (phi_a_o),
  .phi_b_i (phi_b_o),
  .cnt_i   (toggle_cnt_o)
);

// File: tb/test_pfm_clkgen.sv
module test_pfm_clkgen;
  localparam int CNT_W  = 8;
  localparam int DEAD_W = 2;
  localparam int SYNC   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cmp = 1'b0, bypass = 1'b0;
  logic [DEAD_W-1:0] dead = 2'd1;
  logic sw, pa, pb;
  logic [CNT_W-1:0] cnt;

  always #2 clk = ~clk;  // 250 MHz

  pfm_clkgen #(.CNT_W(CNT_W), .DEAD_W(DEAD_W), .SYNC_STAGES(SYNC)) i_pfm_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .cmp_i(cmp), .bypass_i(bypass),
    .dead_i(dead), .sw_clk_o(sw), .phi_a_o(pa), .phi_b_o(pb), .toggle_cnt_o(cnt));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string seg = "R1";
  int tick_per = 4;   // 0 = no strobes
  int cmp_mode = 1;   // 0 const0, 1 const1, 2 lfsr, 3 alternate per strobe
  logic [15:0] lfsr = 16'hACE1;
  int tph = 0;
  bit alt = 0;

  // behavioural reference
  int m_sw, m_cnt, m_ph, m_dc;
  int mode_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sw = 0; m_cnt = 0; m_ph = 0; m_dc = 0;
      mode_q = {};
      for (int i = 0; i < SYNC; i++) mode_q.push_back(0);
    end else begin
      int deff, mused;
      deff = (dead == 0) ? 1 : int'(dead);
      if (m_ph == 1) begin
        if (m_sw == 0) begin m_ph = 0; m_dc = 0; end
      end else if (m_ph == 2) begin
        if (m_sw == 1) begin m_ph = 0; m_dc = 0; end
      end else begin
        if (m_dc >= deff - 1) begin m_ph = m_sw ? 1 : 2; m_dc = 0; end
        else m_dc++;
      end
      mused = mode_q.pop_front();
      mode_q.push_back(int'(bypass));
      if (tick && (mused != 0 || cmp)) begin
        m_sw ^= 1;
        m_cnt = (m_cnt + 1) % (1 << CNT_W);
      end
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(seg, "sw_clk", int'(sw), m_sw);
      chk(seg, "phi_a", int'(pa), m_ph == 1 ? 1 : 0);
      chk(seg, "phi_b", int'(pb), m_ph == 2 ? 1 : 0);
      chk(seg, "toggle_cnt", int'(cnt), m_cnt);
      chk("R7", "overlap", int'(pa & pb), 0);
    end
    // drive next inputs
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (tick_per == 0) tick = 1'b0;
    else begin
      tick = (tph == 0);
      tph = (tph + 1) % tick_per;
    end
    case (cmp_mode)
      0: cmp = 1'b0;
      1: cmp = 1'b1;
      2: cmp = lfsr[0];
      default: begin if (tick) alt = ~alt; cmp = alt; end
    endcase
  end

  task automatic run(input string r, input int per, input int cm, input int n);
    @(posedge clk);
    seg = r; tick_per = per; cmp_mode = cm;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);     // R1 reset values compared each cycle
    @(negedge clk); rst_n = 1'b1;
    run("R2", 16, 1, 200);
    run("R3", 16, 0, 120);
    run("R4", 0, 1, 60);
    run("R2", 4, 3, 200);
    @(posedge clk); bypass = 1'b1;
    run("R5", 1, 0, 100);
    @(posedge clk); bypass = 1'b0;
    run("R5", 1, 0, 40);
    run("R6", 3, 2, 400);
    @(posedge clk); dead = 2'd2;
    run("R8", 12, 1, 200);
    @(posedge clk); dead = 2'd3;
    run("R8", 12, 2, 300);
    @(posedge clk); dead = 2'd0;
    run("R8", 8, 1, 200);
    @(posedge clk); dead = 2'd3;
    run("R9", 1, 2, 300);
    @(posedge clk); bypass = 1'b1;
    run("R10", 1, 0, 700);
    @(posedge clk); rst_n = 1'b0;
    run("R1", 2, 1, 10);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog %s act=hung exp=done", seg);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule